// File: doc/BRIEF.md
# Threshold Window Trigger

This block watches a stream of unsigned samples and decides, sample by sample, whether a trigger condition holds. Two thresholds, a lower and an upper one, are set through a small configuration port together with a mode code. The block drives a level output that stays high while the condition holds and a single-cycle pulse on each low-to-high change of that level. A downstream acquisition or waveform sequencer would use the pulse to start its work and the level for gating.

There are five modes. Three have no memory: sample under the lower threshold, sample over the upper threshold, and sample within the window between them. Two are hysteresis modes with a rising or a falling slope. In these, one threshold is the firing point and the other is the re-arm point, so a noisy signal near the firing point produces one trigger and not a burst. Writing a configuration loads both thresholds and the mode at once, clears the level and re-arms the hysteresis logic.

Samples arrive on a valid/ready interface. Ready is low only in a cycle with a configuration write. A sample offered in that cycle is not taken and has to be held by the source until ready returns, which is always the next cycle. This means no sample is ever judged against a half-applied configuration.

Top module: `thresh_window_trig`

## Requirements
- R1: After reset the level and pulse outputs are 0, the lower threshold is 0, the upper threshold is all ones, the mode is 0 and the hysteresis logic is armed.
- R2: `s_ready` equals the inverse of `cfg_we`. A sample presented while `cfg_we` is high is not taken and changes neither output.
- R3: A configuration write clears the level and the pulse on the following clock and re-arms the hysteresis logic. The new thresholds and mode apply to every sample taken afterwards.
- R4: In mode 0 the level after a taken sample x is 1 exactly when x < lower.
- R5: In mode 1 the level after a taken sample x is 1 exactly when x > upper.
- R6: In mode 2 the level after a taken sample x is 1 exactly when lower <= x <= upper (both ends inclusive).
- R7: Mode 3 is rising hysteresis. While armed, a sample x > upper sets the level and disarms. While disarmed, a sample x < lower clears the level and re-arms. Other samples leave the level unchanged.
- R8: Mode 4 is falling hysteresis. While armed, a sample x < lower sets the level and disarms. While disarmed, a sample x > upper clears the level and re-arms.
- R9: Mode codes 5, 6 and 7 hold the level at 0 for every sample.
- R10: The level changes only on the clock edge that takes a sample, or on the edge after a configuration write. It holds through cycles with no taken sample.
- R11: `trig_pulse` is high for exactly the one cycle in which the level has just gone from 0 to 1 because of a taken sample, and is 0 otherwise.
- R12: The thresholds are independent of each other. With lower > upper, mode 2 never asserts and the other modes still follow their own rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Sample present |
| s_ready | output | 1 | Sample accepted when high together with s_valid |
| s_data | input | DATA_W (8) | Unsigned sample |
| cfg_we | input | 1 | Load thresholds and mode, re-arm |
| cfg_lower | input | DATA_W (8) | Lower threshold |
| cfg_upper | input | DATA_W (8) | Upper threshold |
| cfg_mode | input | 3 | Mode code 0..4 (5..7 inactive) |
| trig_level | output | 1 | Registered trigger level |
| trig_pulse | output | 1 | One-cycle pulse on level rise |

## Verification
The one hidden piece of state is the arm flag of the hysteresis modes, and it cannot be read directly. A wrong arm flag shows up the next time a sample crosses the firing threshold: the pulse is missing, or the pulse repeats where only one is allowed. A wrong stored threshold or mode shows up in the level one clock after the first sample that lands between the correct and the faulty threshold value. The bench therefore drives dense crossings around both thresholds in every mode and compares the outputs on every clock, so such a fault is seen within a few samples.

// File: rtl/twt_pkg.sv
package twt_pkg;
  typedef enum logic [2:0] {
    TM_UNDER   = 3'd0,
    TM_OVER    = 3'd1,
    TM_WINDOW  = 3'd2,
    TM_HYS_UP  = 3'd3,
    TM_HYS_DN  = 3'd4
  } trig_mode_e;

  localparam int MODE_W = 3;

  typedef struct packed {
    logic below_lo;
    logic above_hi;
    logic in_window;
  } cmp_flags_t;
endpackage

// File: rtl/twt_cfg_bank.sv
module twt_cfg_bank #(
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [DATA_W-1:0]         lower_in,
  input  logic [DATA_W-1:0]         upper_in,
  input  logic [twt_pkg::MODE_W-1:0] mode_in,
  output logic [DATA_W-1:0]         lower_q,
  output logic [DATA_W-1:0]         upper_q,
  output logic [twt_pkg::MODE_W-1:0] mode_q
);
  localparam logic [DATA_W-1:0] TOP_VAL = {DATA_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lower_q <= '0;
      upper_q <= TOP_VAL;
      mode_q  <= '0;
    end else if (we) begin
      lower_q <= lower_in;
      upper_q <= upper_in;
      mode_q  <= mode_in;
    end
  end
endmodule

// File: rtl/twt_cmp.sv
module twt_cmp #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] sample,
  input  logic [DATA_W-1:0] lower,
  input  logic [DATA_W-1:0] upper,
  output twt_pkg::cmp_flags_t flags
);
  logic lt_lo, gt_hi;

  always_comb begin
    lt_lo = (sample < lower);
    gt_hi = (sample > upper);
    flags.below_lo  = lt_lo;
    flags.above_hi  = gt_hi;
    flags.in_window = !lt_lo && !gt_hi;
  end
endmodule

// File: rtl/twt_decide.sv
module twt_decide (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rearm,
  input  logic                       take,
  input  logic [twt_pkg::MODE_W-1:0] mode,
  input  twt_pkg::cmp_flags_t        flags,
  output logic                       level_q,
  output logic                       pulse_q
);
  import twt_pkg::*;

  logic armed_q;
  logic level_n, armed_n;

  always_comb begin
    level_n = level_q;
    armed_n = armed_q;
    case (mode)
      TM_UNDER:  level_n = flags.below_lo;
      TM_OVER:   level_n = flags.above_hi;
      TM_WINDOW: level_n = flags.in_window;
      TM_HYS_UP: begin
        if (armed_q && flags.above_hi)       armed_n = 1'b0;
        else if (!armed_q && flags.below_lo) armed_n = 1'b1;
        level_n = !armed_n;
      end
      TM_HYS_DN: begin
        if (armed_q && flags.below_lo)       armed_n = 1'b0;
        else if (!armed_q && flags.above_hi) armed_n = 1'b1;
        level_n = !armed_n;
      end
      default:   level_n = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      pulse_q <= 1'b0;
      armed_q <= 1'b1;
    end else if (rearm) begin
      level_q <= 1'b0;
      pulse_q <= 1'b0;
      armed_q <= 1'b1;
    end else if (take) begin
      level_q <= level_n;
      pulse_q <= level_n && !level_q;
      armed_q <= armed_n;
    end else begin
      pulse_q <= 1'b0;
    end
  end
endmodule

// File: rtl/thresh_window_trig.sv
module thresh_window_trig #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_lower,
  input  logic [DATA_W-1:0] cfg_upper,
  input  logic [2:0]        cfg_mode,
  output logic              trig_level,
  output logic              trig_pulse
);
  import twt_pkg::*;

  logic [DATA_W-1:0] lower_q, upper_q;
  logic [MODE_W-1:0] mode_q;
  cmp_flags_t        flags;
  logic              take;

  assign s_ready = !cfg_we;
  assign take    = s_valid && s_ready;

  twt_cfg_bank #(.DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we),
    .lower_in(cfg_lower), .upper_in(cfg_upper), .mode_in(cfg_mode),
    .lower_q(lower_q), .upper_q(upper_q), .mode_q(mode_q)
  );

  twt_cmp #(.DATA_W(DATA_W)) u_cmp (
    .sample(s_data), .lower(lower_q), .upper(upper_q), .flags(flags)
  );

  twt_decide u_dec (
    .clk(clk), .rst_n(rst_n), .rearm(cfg_we), .take(take),
    .mode(mode_q), .flags(flags),
    .level_q(trig_level), .pulse_q(trig_pulse)
  );
endmodule

// File: rtl/twt_chk.sv
module twt_chk (
  input logic clk,
  input logic rst_n,
  input logic s_valid,
  input logic s_ready,
  input logic cfg_we,
  input logic trig_level,
  input logic trig_pulse
);
  // R2
  ready_vs_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !s_ready);

  // R3
  cfg_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (!trig_level && !trig_pulse));

  // R10
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(s_valid && s_ready) && !cfg_we) |=> $stable(trig_level));

  // R11
  pulse_has_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> trig_level);

  // R11
  pulse_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_level) |-> trig_pulse);
endmodule

bind thresh_window_trig twt_chk u_twt_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .cfg_we(cfg_we), .trig_level(trig_level), .trig_pulse(trig_pulse)
);

// File: tb/thresh_window_trig_tb_top.sv
`timescale 1ns/1ps
module thresh_window_trig_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s_valid = 1'b0;
  logic       s_ready;
  logic [7:0] s_data = '0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_lower = '0;
  logic [7:0] cfg_upper = '0;
  logic [2:0] cfg_mode = '0;
  logic       trig_level, trig_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_lo = 0, m_hi = 255, m_mode = 0;
  bit m_armed = 1, m_level = 0, m_pulse = 0;

  always #5 clk = ~clk;

  thresh_window_trig dut_i (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .cfg_we(cfg_we), .cfg_lower(cfg_lower),
    .cfg_upper(cfg_upper), .cfg_mode(cfg_mode),
    .trig_level(trig_level), .trig_pulse(trig_pulse)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_sample(int x);
    bit nl;
    nl = m_level;
    case (m_mode)
      0: nl = (x < m_lo);
      1: nl = (x > m_hi);
      2: nl = (x >= m_lo) && (x <= m_hi);
      3: begin
        if (m_armed && x > m_hi) begin m_armed = 0; nl = 1; end
        else if (!m_armed && x < m_lo) begin m_armed = 1; nl = 0; end
      end
      4: begin
        if (m_armed && x < m_lo) begin m_armed = 0; nl = 1; end
        else if (!m_armed && x > m_hi) begin m_armed = 1; nl = 0; end
      end
      default: nl = 0;
    endcase
    m_pulse = nl && !m_level;
    m_level = nl;
  endtask

  // one clock: drive at negedge, check ready, update model at posedge, compare after
  task automatic step(string tag, bit v, int x, bit we, int lo, int hi, int md);
    @(negedge clk);
    s_valid = v; s_data = 8'(x); cfg_we = we;
    cfg_lower = 8'(lo); cfg_upper = 8'(hi); cfg_mode = 3'(md);
    #1;
    check("R2", "s_ready", s_ready, !we);
    @(posedge clk);
    if (we) begin
      m_lo = lo; m_hi = hi; m_mode = md;
      m_level = 0; m_pulse = 0; m_armed = 1;
    end else if (v) model_sample(x);
    else m_pulse = 0;
    #1;
    check(tag, "level", trig_level, m_level);
    check(tag, "pulse", trig_pulse, m_pulse);
  endtask

  task automatic cfg(string tag, int lo, int hi, int md);
    step(tag, 0, 0, 1, lo, hi, md);
  endtask

  task automatic smp(string tag, int x);
    step(tag, 1, x, 0, 0, 0, 0);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic sweep(string tag, int lo, int hi, int n);
    for (int i = 0; i < n; i++) begin
      int x;
      x = (lo + hi) / 2 + int'($urandom_range(0, 80)) - 40;
      if (x < 0) x = 0;
      if (x > 255) x = 255;
      if ($urandom_range(0, 4) == 0) idle(tag);
      else smp(tag, x);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", "level", trig_level, 0);
    check("R1", "pulse", trig_pulse, 0);
    rst_n = 1'b1;
    // R1 default thresholds: mode 0 with lower 0 never fires
    smp("R1", 0); smp("R1", 255);
    // R1 default upper all ones: mode 1 (via cfg only mode) -- check armed via hysteresis
    cfg("R3", 100, 150, 0);
    smp("R4", 99); smp("R4", 100); smp("R4", 0); smp("R4", 101);
    idle("R10"); idle("R10");
    smp("R4", 50); idle("R10");
    // R2: sample offered with cfg write is ignored (would fire under mode 0)
    step("R2", 1, 10, 1, 100, 150, 1);
    smp("R5", 150); smp("R5", 151); smp("R5", 255); smp("R5", 3); smp("R5", 200);
    // R3: config clears level while high
    cfg("R3", 100, 150, 2);
    smp("R6", 100); smp("R6", 150); smp("R6", 99); smp("R6", 151); smp("R6", 125);
    // R12: inverted thresholds, window never asserts
    cfg("R12", 200, 50, 2);
    smp("R12", 100); smp("R12", 50); smp("R12", 200); smp("R12", 0);
    // R7 rising hysteresis
    cfg("R7", 80, 160, 3);
    smp("R7", 161); smp("R7", 140); smp("R7", 200); smp("R7", 170);
    smp("R7", 80); smp("R7", 79); smp("R7", 100); smp("R7", 161);
    // R3 re-arm by config while disarmed
    cfg("R3", 80, 160, 3);
    smp("R3", 170);
    // R8 falling hysteresis
    cfg("R8", 80, 160, 4);
    smp("R8", 79); smp("R8", 10); smp("R8", 160); smp("R8", 90);
    smp("R8", 161); smp("R8", 100); smp("R8", 0);
    // R9 inactive codes
    for (int c = 5; c < 8; c++) begin
      cfg("R9", 100, 150, c);
      smp("R9", 0); smp("R9", 125); smp("R9", 255);
    end
    // R12 inverted thresholds in hysteresis
    cfg("R12", 200, 50, 3);
    smp("R12", 100); smp("R12", 100); smp("R12", 30);
    // dense sweeps per mode
    sweep("R4", 120, 130, 0);
    cfg("R4", 110, 140, 0); sweep("R4", 110, 140, 150);
    cfg("R5", 110, 140, 1); sweep("R5", 110, 140, 150);
    cfg("R6", 110, 140, 2); sweep("R6", 110, 140, 150);
    cfg("R7", 110, 140, 3); sweep("R7", 110, 140, 300);
    cfg("R8", 110, 140, 4); sweep("R8", 110, 140, 300);
    cfg("R11", 125, 125, 3); sweep("R11", 125, 125, 200);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule